// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single-channel countdown timer with a small word-addressed register bus and one interrupt output. Software programs a 23-bit start value and a control word. An internal prescaler divides the peripheral clock by 1, 16 or 256, and the counter steps down by one on each divided tick. When the count reaches zero the timer raises an interrupt event. In auto-reload mode the counter then takes the programmed value again, which gives a periodic interrupt. In one-shot mode it stays at zero until the next tick, then wraps to all ones and keeps counting.

The interrupt is either a one-clock pulse per event or a level that is held until software writes the clear register. A pending flag in the control word shows that an event has occurred. Clearing the enable bit freezes the count and the prescaler where they are. A frozen count of zero never produces interrupts, because the zero event only fires on an enabled tick that moves the count from one to zero. For example, an 80 MHz clock divided by 256 with a start value of 312500 gives a one-second period.

Top module: `ivt_timer`

## Requirements
- R1: After a synchronous active-low reset, the start value, count, control word and pending flag are all zero and `irq` is low.
- R2: Register words are selected by `bus_addr`: 0 = start value (read/write, 23 bits, upper bits read zero); 1 = current count (read only); 2 = control; 3 = interrupt clear (any write clears, reads zero). Control bits: bit 0 level mode, bits 3:2 prescaler code, bit 6 auto-reload, bit 7 enable, bit 8 pending (read only). All other bits read zero.
- R3: A write to word 0 copies bits 22:0 into the counter at that clock edge, whether or not the timer is enabled. When the write lands in the same cycle as a tick, the write wins and no zero event occurs.
- R4: Prescaler code 0 divides by 1, code 1 by 16, and codes 2 and 3 both by 256. Every control write restarts the prescaler phase, so with divide-by-N the first decrement happens N clock edges after the edge that enabled the timer.
- R5: A tick with count 1 moves the count to zero and signals one zero event.
- R6: With auto-reload set, the zero event loads the start value instead of zero, so a start value L gives one event every L ticks.
- R7: With auto-reload clear, the count stays zero after the event until the next tick. That tick sets it to 0x7FFFFF, and the countdown continues.
- R8: While enable is clear, the count and the prescaler phase hold their values. Nothing is reset.
- R9: A disabled timer holding a count of zero never raises `irq` and never sets the pending flag.
- R10: In edge mode (bit 0 = 0), `irq` is high for exactly the one clock cycle after the edge at which the event occurs.
- R11: In level mode (bit 0 = 1), `irq` follows the pending flag and stays high until a write to word 3. If a clear and an event fall in the same cycle, the event wins.
- R12: Every zero event sets pending bit 8, in either mode, and a write to word 3 with no event in that cycle clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Interrupt output, pulse or level by mode |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a start-value write and the tick that would take the count from one to zero. The second is an interrupt-clear write and a new zero event in level mode. The bench provokes each collision with divide-by-1 and a start value of 2, issuing the write two edges after the enabling write. It then judges the result at the ports. In the load case, the count must show the written value and `irq` and pending must stay low. In the clear case, `irq` and pending must remain high.

// File: rtl/ivt_timer_pkg.sv
// Package: shared widths, word addresses and control-bit positions of the
// interval timer. Bit positions are fixed because software decodes them.
package ivt_timer_pkg;
    localparam int unsigned CNT_W   = 23;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned DIV_MID = 16;
    localparam int unsigned DIV_MAX = 256;
    localparam int unsigned PRE_W   = $clog2(DIV_MAX);

    typedef enum logic [ADDR_W-1:0] {
        WORD_START = 2'd0,
        WORD_COUNT = 2'd1,
        WORD_CTRL  = 2'd2,
        WORD_CLEAR = 2'd3
    } word_e;

    localparam int unsigned BIT_LEVEL  = 0;
    localparam int unsigned BIT_DIV_LO = 2;
    localparam int unsigned BIT_RELOAD = 6;
    localparam int unsigned BIT_EN     = 7;
    localparam int unsigned BIT_PEND   = 8;
endpackage

// File: rtl/ivt_prescale.sv
// Module: clock prescaler. Emits a one-cycle tick every 1, 16 or 256
// enabled cycles, chosen by a 2-bit code (codes 2 and 3 alike).
// Assumes restart is pulsed on every control write; phase holds while disabled.
module ivt_prescale #(
    parameter int unsigned DIV_MID = 16,
    parameter int unsigned DIV_MAX = 256,
    localparam int unsigned PRE_W  = $clog2(DIV_MAX)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    // Map the code to the last phase value of a division period.
    always_comb begin
        unique case (code)
            2'd0:    limit = '0;
            2'd1:    limit = PRE_W'(DIV_MID - 1);
            default: limit = PRE_W'(DIV_MAX - 1);
        endcase
    end

    assign tick = en && (phase_q == limit);

    // Advance the phase while enabled; a control write restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (en)      phase_q <= tick ? '0 : phase_q + 1'b1;
    end

    assert_tick_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_q) || $past(restart));
endmodule

// File: rtl/ivt_counter.sv
// Module: 23-bit down counter. Decrements on tick, reloads on a zero event
// when auto-reload is set, and wraps through all-ones otherwise. A start
// write overrides everything in its cycle and suppresses the event.
module ivt_counter #(
    parameter int unsigned CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);
    logic [CNT_W-1:0] count_q;

    assign zero_evt = tick && !ld_wr && (count_q == CNT_W'(1));
    assign count    = count_q;

    // Update the count: start write first, then the reload, then a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_q <= '0;
        else if (ld_wr)                   count_q <= ld_val;
        else if (zero_evt && reload_en)   count_q <= reload_val;
        else if (tick)                    count_q <= count_q - CNT_W'(1);
    end

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> count_q == $past(ld_val));
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_wr) |=> $stable(count_q));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_wr && count_q == '0) |=> count_q == {CNT_W{1'b1}});
endmodule

// File: rtl/ivt_irq.sv
// Module: interrupt shaping. Holds the pending flag and produces either a
// one-clock pulse per event (edge mode) or a level held until clear.
// Assumes zero_evt is a single-cycle strobe; set wins over a same-cycle clear.
module ivt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic clr,
    input  logic level_mode,
    output logic pending,
    output logic irq
);
    logic pend_q;
    logic pulse_q;

    // Track pending events; a new event outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (zero_evt) pend_q <= 1'b1;
        else if (clr)      pend_q <= 1'b0;
    end

    // Register the event as a one-clock pulse for edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= zero_evt;
    end

    assign pending = pend_q;
    assign irq     = level_mode ? pend_q : pulse_q;

    assert_pend_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(zero_evt));
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !zero_evt) |=> !pend_q);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> pend_q);
endmodule

// File: rtl/ivt_timer.sv
// Module: top of the interval timer. Decodes the four-word register bus,
// holds the start value and control fields, and wires the prescaler,
// counter and interrupt shaper. Reads are combinational on bus_addr.
module ivt_timer
    import ivt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] start_q;
    logic             level_q;
    logic [1:0]       div_q;
    logic             reload_q;
    logic             en_q;

    logic             wr_start;
    logic             wr_ctrl;
    logic             wr_clear;
    logic             tick;
    logic             zero_evt;
    logic             pending;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_start = bus_wr && (bus_addr == WORD_START);
    assign wr_ctrl  = bus_wr && (bus_addr == WORD_CTRL);
    assign wr_clear = bus_wr && (bus_addr == WORD_CLEAR);

    // Capture the start value.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (wr_start) start_q <= bus_wdata[CNT_W-1:0];
    end

    // Capture the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            div_q    <= 2'd0;
            reload_q <= 1'b0;
            en_q     <= 1'b0;
        end else if (wr_ctrl) begin
            level_q  <= bus_wdata[BIT_LEVEL];
            div_q    <= bus_wdata[BIT_DIV_LO +: 2];
            reload_q <= bus_wdata[BIT_RELOAD];
            en_q     <= bus_wdata[BIT_EN];
        end
    end

    ivt_prescale #(.DIV_MID(DIV_MID), .DIV_MAX(DIV_MAX)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .restart (wr_ctrl),
        .code    (div_q),
        .tick    (tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ld_wr      (wr_start),
        .ld_val     (bus_wdata[CNT_W-1:0]),
        .reload_en  (reload_q),
        .reload_val (start_q),
        .count      (count),
        .zero_evt   (zero_evt)
    );

    ivt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_evt   (zero_evt),
        .clr        (wr_clear),
        .level_mode (level_q),
        .pending    (pending),
        .irq        (irq)
    );

    // Assemble the control word; reserved bits read zero.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[BIT_LEVEL]         = level_q;
        ctrl_word[BIT_DIV_LO +: 2]   = div_q;
        ctrl_word[BIT_RELOAD]        = reload_q;
        ctrl_word[BIT_EN]            = en_q;
        ctrl_word[BIT_PEND]          = pending;
    end

    // Select the read word.
    always_comb begin
        unique case (bus_addr)
            WORD_START: bus_rdata = DATA_W'(start_q);
            WORD_COUNT: bus_rdata = DATA_W'(count);
            WORD_CTRL:  bus_rdata = ctrl_word;
            default:    bus_rdata = '0;
        endcase
    end

    assert_no_fire_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !zero_evt);
    assert_frozen_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_start) |=> $stable(count));
endmodule

// File: tb/ivt_timer_bench.sv
`timescale 1ns/1ps
// Directed bench for the interval timer: one task per scenario.
module ivt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ivt_timer u_ivt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write lands on the posedge after the next negedge; returns at the following negedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic quiesce();
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 start", d, 0);
        rd(2'd1, d); check("R1 count", d, 0);
        rd(2'd2, d); check("R1 ctrl", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R2 start width", d, 32'h7F_FFFF);
        rd(2'd1, d); check("R3 immediate load", d, 32'h7F_FFFF);
        wr(2'd2, 32'hFFFF_FF7F);
        rd(2'd2, d); check("R2 ctrl reserved zero", d, 32'h4D);
        rd(2'd3, d); check("R2 clear reads zero", d, 0);
        wr(2'd1, 32'h55);
        rd(2'd1, d); check("R2 count read only", d, 32'h7F_FFFF);
        quiesce();
    endtask

    task automatic t_oneshot_edge();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 5);
        wr(2'd2, 32'h80);
        repeat (4) @(negedge clk);
        rd(2'd1, d); check("R5 count one", d, 1);
        check("R10 no early irq", irq, 0);
        @(negedge clk);
        rd(2'd1, d); check("R5 reaches zero", d, 0);
        check("R10 pulse", irq, 1);
        rd(2'd2, d); check("R12 pending set", d[8], 1);
        @(negedge clk);
        rd(2'd1, d); check("R7 wrap", d, 32'h7F_FFFF);
        check("R10 pulse one clock", irq, 0);
        @(negedge clk);
        rd(2'd1, d); check("R7 continues", d, 32'h7F_FFFE);
        wr(2'd3, 0);
        rd(2'd2, d); check("R12 pending cleared", d[8], 0);
    endtask

    task automatic t_reload();
        logic [31:0] d;
        int pulses = 0;
        quiesce();
        wr(2'd0, 3);
        wr(2'd2, 32'hC0);
        repeat (3) @(negedge clk);
        rd(2'd1, d); check("R6 reload value", d, 3);
        check("R6 first event", irq, 1);
        pulses = 1;
        for (int i = 0; i < 27; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check("R6 period events", pulses, 10);
    endtask

    task automatic t_div16();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 2);
        wr(2'd2, 32'h84);
        repeat (15) @(negedge clk);
        rd(2'd1, d); check("R4 div16 hold", d, 2);
        @(negedge clk);
        rd(2'd1, d); check("R4 div16 first step", d, 1);
        repeat (15) @(negedge clk);
        check("R4 div16 no early irq", irq, 0);
        @(negedge clk);
        check("R4 div16 event", irq, 1);
    endtask

    task automatic t_div256(input logic [31:0] code_ctrl, input string tag);
        logic [31:0] d;
        quiesce();
        wr(2'd0, 1);
        wr(2'd2, code_ctrl);
        repeat (255) @(negedge clk);
        rd(2'd1, d); check({"R4 div256 hold ", tag}, d, 1);
        check({"R4 div256 quiet ", tag}, irq, 0);
        @(negedge clk);
        rd(2'd1, d); check({"R4 div256 zero ", tag}, d, 0);
        check({"R4 div256 irq ", tag}, irq, 1);
    endtask

    task automatic t_level();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 2);
        wr(2'd2, 32'h81);
        repeat (2) @(negedge clk);
        check("R11 level rises", irq, 1);
        repeat (10) @(negedge clk);
        check("R11 level held", irq, 1);
        wr(2'd3, 0);
        check("R11 level cleared", irq, 0);
        rd(2'd2, d); check("R12 clear drops pending", d[8], 0);
    endtask

    task automatic t_disable_at_zero();
        logic [31:0] d;
        int seen = 0;
        quiesce();
        wr(2'd0, 1);
        wr(2'd2, 32'h84);
        repeat (16) @(negedge clk);
        check("R5 div16 zero edge", irq, 1);
        wr(2'd2, 32'h04);
        wr(2'd3, 0);
        rd(2'd1, d); check("R8 frozen at zero", d, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        check("R9 no flood edge", seen, 0);
        wr(2'd2, 32'h05);
        repeat (50) @(negedge clk);
        check("R9 no flood level", irq, 0);
        rd(2'd2, d); check("R9 pending stays clear", d[8], 0);
        rd(2'd1, d); check("R8 count still zero", d, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 100);
        wr(2'd2, 32'h80);
        wr(2'd2, 32'h00);
        rd(2'd1, d);
        repeat (20) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(2'd1, d2); check("R8 count frozen", d2, d);
        end
        check("R8 not reset", (d < 100) && (d > 90), 1);
    endtask

    task automatic t_load_vs_event();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 2);
        wr(2'd2, 32'h80);
        wr(2'd0, 32'h40);
        rd(2'd1, d); check("R3 load beats event", d, 32'h40);
        check("R3 no irq on collision", irq, 0);
        rd(2'd2, d); check("R3 no pending on collision", d[8], 0);
    endtask

    task automatic t_clear_vs_event();
        logic [31:0] d;
        quiesce();
        wr(2'd0, 2);
        wr(2'd2, 32'h81);
        wr(2'd3, 0);
        check("R11 set beats clear", irq, 1);
        rd(2'd2, d); check("R12 pending kept", d[8], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_oneshot_edge();
        t_reload();
        t_div16();
        t_div256(32'h88, "code2");
        t_div256(32'h8C, "code3");
        t_level();
        t_disable_at_zero();
        t_freeze();
        t_load_vs_event();
        t_clear_vs_event();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule